// File: doc/BRIEF.md
# Clock Root Configuration Register Block

This block is the register front end of one clock root generator. Software programs a source select, a pre-divider, an M/N mode and three M/N/D counter values into shadow registers over a simple register bus. None of these values reach the divider datapath directly. The datapath is fed from a separate active copy, and that copy changes only when an update has been requested and has been carried out.

Software requests an update by setting the request bit in the command register and then polls that bit. The block copies every shadow register into the active copy in one cycle and clears the request bit to acknowledge. While the root is enabled, the copy waits for a safe-point strobe from the glitch-free source multiplexer. While the root is disabled, the copy happens on the next clock edge. Each shadow register has a dirty flag that shows it was written after the last copy. The command register also shows whether the root is off. Register reads are combinational from the address.

Top module: `clkroot_cfg`

## Requirements
- R1: After reset, the command register (offset 0x0) reads 0x8000_0000. Every other register, every active output and dual_edge_o read 0.
- R2: Shadow writes are masked to their fields, and unused bits read 0. M (0x8), N (0xC) and D (0x10) keep their low CR_MN_W bits. The configuration register (0x4) keeps the pre-divider in bits CR_DIV_W-1:0, the 3-bit source select in bits 10:8 and the 2-bit mode in bits 13:12.
- R3: A write to a shadow register sets its dirty flag in the command register: bit 4 for configuration, bit 5 for N, bit 6 for M, bit 7 for D. The write leaves the active outputs unchanged.
- R4: Writing 1 to command bit 0 sets the pending update, and bit 0 reads 1 while it is pending. Writing 0 to bit 0 does not cancel a pending update.
- R5: While command bit 1 (root enable) is 1 and safe_pt is low, a pending update stays pending and the active outputs hold.
- R6: At a clock edge where an update is pending and safe_pt is high, every active output takes its shadow value, and bit 0 and all four dirty flags clear.
- R7: If an update is requested while the root enable is 0, the copy and acknowledge happen at the first clock edge after the edge that registered the request, whatever safe_pt is.
- R8: Command bit 1 reads back the root enable, and root_en_o follows it. Bit 31 reads 1 exactly when the root enable is 0.
- R9: If a shadow write lands on the same edge as a copy, the active copy takes the old shadow value, the shadow takes the new value, and that register's dirty flag stays set.
- R10: Offsets other than 0x0, 0x4, 0x8, 0xC and 0x10 read 0, and writes to them change no register.
- R11: dual_edge_o is high exactly when the active mode field equals 2. Mode 0 means the M/N stage is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | CR_ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| safe_pt | input | 1 | Strobe from the source multiplexer marking a safe switch point |
| root_en_o | output | 1 | Root enable to the clock gate |
| act_src_o | output | 3 | Active source select |
| act_div_o | output | CR_DIV_W | Active pre-divider |
| act_mode_o | output | 2 | Active M/N mode |
| act_m_o | output | CR_MN_W | Active M value |
| act_n_o | output | CR_MN_W | Active N value |
| act_d_o | output | CR_MN_W | Active D value |
| dual_edge_o | output | 1 | Active mode selects dual-edge M/N operation |

## Verification
The assertions assume that safe_pt and every bus input are synchronous to clk and settled at the rising edge. They also assume a write is one cycle of bus_wr with a single address. The bench meets this by driving every input at the falling edge and holding each write strobe for exactly one cycle. The bench raises safe_pt as a one-cycle pulse, and only while an update is pending with the root enabled. This keeps the copy at one known edge, so the bench can predict its timing exactly. The random phase draws addresses from both the mapped and unmapped offsets, and its data covers all 32 bits, so masking and ignored writes come up on their own.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
    parameter int CR_MN_W   = 8;
    parameter int CR_DIV_W  = 5;
    parameter int CR_SRC_W  = 3;
    parameter int CR_MODE_W = 2;
    parameter int CR_ADDR_W = 5;

    localparam int CR_OFS_CMD = 'h00;
    localparam int CR_OFS_CFG = 'h04;
    localparam int CR_OFS_M   = 'h08;
    localparam int CR_OFS_N   = 'h0C;
    localparam int CR_OFS_D   = 'h10;

    localparam int CR_SRC_LSB   = 8;
    localparam int CR_MODE_LSB  = 12;
    localparam int CR_REQ_BIT   = 0;
    localparam int CR_EN_BIT    = 1;
    localparam int CR_DIRTY_LSB = 4;
    localparam int CR_OFF_BIT   = 31;
    localparam int CR_NDIRTY    = 4;

    localparam int DRT_CFG = 0;
    localparam int DRT_N   = 1;
    localparam int DRT_M   = 2;
    localparam int DRT_D   = 3;

    localparam logic [CR_MODE_W-1:0] CR_MODE_DUAL = 2'd2;

    typedef struct packed {
        logic [CR_SRC_W-1:0]  src;
        logic [CR_MODE_W-1:0] mode;
        logic [CR_DIV_W-1:0]  div;
        logic [CR_MN_W-1:0]   m;
        logic [CR_MN_W-1:0]   n;
        logic [CR_MN_W-1:0]   d;
    } rootcfg_t;
endpackage

// File: rtl/clkroot_shadow.sv
module clkroot_shadow
    import clkroot_pkg::*;
#(
    parameter int ADDR_W = CR_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic                  commit,
    output rootcfg_t              shd,
    output logic [CR_NDIRTY-1:0]  dirty
);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CR_OFS_CFG);
    localparam logic [ADDR_W-1:0] A_M   = ADDR_W'(CR_OFS_M);
    localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(CR_OFS_N);
    localparam logic [ADDR_W-1:0] A_D   = ADDR_W'(CR_OFS_D);

    typedef struct packed {
        rootcfg_t              shd;
        logic [CR_NDIRTY-1:0]  dirty;
    } shd_state_t;

    shd_state_t st_d, st_q;
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.dirty = '0;
        end
        if (wr_en) begin
            case (addr)
                A_CFG: begin
                    st_d.shd.div  = wdata[CR_DIV_W-1:0];
                    st_d.shd.src  = wdata[CR_SRC_LSB+CR_SRC_W-1:CR_SRC_LSB];
                    st_d.shd.mode = wdata[CR_MODE_LSB+CR_MODE_W-1:CR_MODE_LSB];
                    st_d.dirty[DRT_CFG] = 1'b1;
                end
                A_M: begin
                    st_d.shd.m = wdata[CR_MN_W-1:0];
                    st_d.dirty[DRT_M] = 1'b1;
                end
                A_N: begin
                    st_d.shd.n = wdata[CR_MN_W-1:0];
                    st_d.dirty[DRT_N] = 1'b1;
                end
                A_D: begin
                    st_d.shd.d = wdata[CR_MN_W-1:0];
                    st_d.dirty[DRT_D] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shd   = st_q.shd;
    assign dirty = st_q.dirty;

    // R3 and R9: an M write marks M dirty, even on a copy edge
    p_m_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_M) |=> dirty[DRT_M]);

    // R6: a copy with no write on the same edge leaves every flag clear
    p_clean_after_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_en) |=> (dirty == '0));
endmodule

// File: rtl/clkroot_update.sv
module clkroot_update
    import clkroot_pkg::*;
#(
    parameter int ADDR_W = CR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              safe_pt,
    output logic              root_en,
    output logic              pend,
    output logic              commit
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CR_OFS_CMD);

    typedef struct packed {
        logic root_en;
        logic pend;
    } upd_state_t;

    upd_state_t st_d, st_q;
    logic       cmd_wr;
    logic       req_wr;
    logic       unused_wdata;

    assign unused_wdata = ^wdata;
    assign cmd_wr = wr_en && (addr == A_CMD);
    assign req_wr = cmd_wr && wdata[CR_REQ_BIT];
    assign commit = st_q.pend && (safe_pt || !st_q.root_en);

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.pend = 1'b0;
        end
        if (cmd_wr) begin
            st_d.root_en = wdata[CR_EN_BIT];
        end
        if (req_wr) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign root_en = st_q.root_en;
    assign pend    = st_q.pend;

    // R5: enabled root without a safe point keeps the request pending
    p_wait_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && root_en && !safe_pt) |=> pend);

    // R7: disabled root acknowledges at the next edge
    p_off_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !root_en && !req_wr) |=> !pend);

    // R4: a request write always leaves the request pending
    p_req_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> pend);
endmodule

// File: rtl/clkroot_active.sv
module clkroot_active
    import clkroot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit,
    input  rootcfg_t shd,
    output rootcfg_t act
);
    typedef struct packed {
        rootcfg_t act;
    } act_state_t;

    act_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.act = shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;

    // R5: the datapath copy only moves on a copy edge
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act));

    // R6: a copy takes the shadow as it stood at that edge
    p_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act == $past(shd)));
endmodule

// File: rtl/clkroot_cfg.sv
module clkroot_cfg
    import clkroot_pkg::*;
#(
    parameter int ADDR_W = CR_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 safe_pt,
    output logic                 root_en_o,
    output logic [CR_SRC_W-1:0]  act_src_o,
    output logic [CR_DIV_W-1:0]  act_div_o,
    output logic [CR_MODE_W-1:0] act_mode_o,
    output logic [CR_MN_W-1:0]   act_m_o,
    output logic [CR_MN_W-1:0]   act_n_o,
    output logic [CR_MN_W-1:0]   act_d_o,
    output logic                 dual_edge_o
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CR_OFS_CMD);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CR_OFS_CFG);
    localparam logic [ADDR_W-1:0] A_M   = ADDR_W'(CR_OFS_M);
    localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(CR_OFS_N);
    localparam logic [ADDR_W-1:0] A_D   = ADDR_W'(CR_OFS_D);

    rootcfg_t              shd;
    rootcfg_t              act;
    logic [CR_NDIRTY-1:0]  dirty;
    logic                  root_en;
    logic                  pend;
    logic                  commit;

    clkroot_update #(.ADDR_W(ADDR_W)) u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .safe_pt (safe_pt),
        .root_en (root_en),
        .pend    (pend),
        .commit  (commit)
    );

    clkroot_shadow #(.ADDR_W(ADDR_W)) u_shd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .commit (commit),
        .shd    (shd),
        .dirty  (dirty)
    );

    clkroot_active u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .shd    (shd),
        .act    (act)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CMD: begin
                bus_rdata[CR_OFF_BIT] = ~root_en;
                bus_rdata[CR_DIRTY_LSB+CR_NDIRTY-1:CR_DIRTY_LSB] = dirty;
                bus_rdata[CR_EN_BIT]  = root_en;
                bus_rdata[CR_REQ_BIT] = pend;
            end
            A_CFG: begin
                bus_rdata[CR_DIV_W-1:0] = shd.div;
                bus_rdata[CR_SRC_LSB+CR_SRC_W-1:CR_SRC_LSB]    = shd.src;
                bus_rdata[CR_MODE_LSB+CR_MODE_W-1:CR_MODE_LSB] = shd.mode;
            end
            A_M:     bus_rdata[CR_MN_W-1:0] = shd.m;
            A_N:     bus_rdata[CR_MN_W-1:0] = shd.n;
            A_D:     bus_rdata[CR_MN_W-1:0] = shd.d;
            default: ;
        endcase
    end

    assign root_en_o   = root_en;
    assign act_src_o   = act.src;
    assign act_div_o   = act.div;
    assign act_mode_o  = act.mode;
    assign act_m_o     = act.m;
    assign act_n_o     = act.n;
    assign act_d_o     = act.d;
    assign dual_edge_o = (act.mode == CR_MODE_DUAL);

    // R8: the enable output tracks the command register across a write
    p_en_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD) |=> (root_en_o == $past(bus_wdata[CR_EN_BIT])));
endmodule

// File: tb/sim_clkroot_cfg.sv
module sim_clkroot_cfg;
    import clkroot_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [CR_ADDR_W-1:0] bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 safe_pt = 1'b0;
    logic                 root_en_o;
    logic [CR_SRC_W-1:0]  act_src_o;
    logic [CR_DIV_W-1:0]  act_div_o;
    logic [CR_MODE_W-1:0] act_mode_o;
    logic [CR_MN_W-1:0]   act_m_o, act_n_o, act_d_o;
    logic                 dual_edge_o;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] s_cfg, s_m, s_n, s_d, a_cfg, a_m, a_n, a_d;
    logic [3:0]  m_dirty;
    logic        m_root, m_pend;

    localparam logic [31:0] MN_MASK  = (32'd1 << CR_MN_W) - 32'd1;
    localparam logic [31:0] CFG_MASK = 32'h0000_3700 | ((32'd1 << CR_DIV_W) - 32'd1);

    always #2 clk = ~clk;

    clkroot_cfg u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .safe_pt(safe_pt),
        .root_en_o(root_en_o), .act_src_o(act_src_o), .act_div_o(act_div_o),
        .act_mode_o(act_mode_o), .act_m_o(act_m_o), .act_n_o(act_n_o),
        .act_d_o(act_d_o), .dual_edge_o(dual_edge_o)
    );

    function automatic logic [31:0] cmd_img();
        return {~m_root, 23'd0, m_dirty, 2'b00, m_root, m_pend};
    endfunction

    function automatic logic [31:0] act_img();
        return 32'(act_div_o) | (32'(act_src_o) << 8) | (32'(act_mode_o) << 12);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdchk(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic mwr(input logic [4:0] a, input logic [31:0] d);
        wr(a, d);
        case (a)
            5'h04: begin s_cfg = d & CFG_MASK; m_dirty[0] = 1'b1; end
            5'h0C: begin s_n = d & MN_MASK; m_dirty[1] = 1'b1; end
            5'h08: begin s_m = d & MN_MASK; m_dirty[2] = 1'b1; end
            5'h10: begin s_d = d & MN_MASK; m_dirty[3] = 1'b1; end
            5'h00: begin m_root = d[1]; if (d[0]) m_pend = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic mcommit();
        a_cfg = s_cfg; a_m = s_m; a_n = s_n; a_d = s_d;
        m_dirty = '0; m_pend = 1'b0;
    endtask

    task automatic chk_act(input string req);
        chk({req, " act cfg"}, act_img(), a_cfg);
        chk({req, " act m"}, 32'(act_m_o), a_m);
        chk({req, " act n"}, 32'(act_n_o), a_n);
        chk({req, " act d"}, 32'(act_d_o), a_d);
        chk("R11 dual edge", 32'(dual_edge_o), 32'(a_cfg[13:12] == 2'd2));
    endtask

    task automatic chk_all(input string req);
        rdchk(5'h04, s_cfg, {req, " rd cfg"});
        rdchk(5'h08, s_m, {req, " rd m"});
        rdchk(5'h0C, s_n, {req, " rd n"});
        rdchk(5'h10, s_d, {req, " rd d"});
        rdchk(5'h00, cmd_img(), {req, " rd cmd"});
        chk("R8 root_en_o", 32'(root_en_o), 32'(m_root));
        chk_act(req);
    endtask

    function automatic logic [4:0] pick_addr(input int unsigned r);
        case (r % 8)
            0: return 5'h04;
            1: return 5'h08;
            2: return 5'h0C;
            3: return 5'h10;
            4: return 5'h14;
            5: return 5'h1C;
            6: return 5'h02;
            default: return 5'h04;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'h5EED_0123;
        void'($urandom(seed));
        s_cfg = 0; s_m = 0; s_n = 0; s_d = 0;
        a_cfg = 0; a_m = 0; a_n = 0; a_d = 0;
        m_dirty = 0; m_root = 0; m_pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk(5'h00, 32'h8000_0000, "R1 cmd reset");
        chk_all("R1");

        // R2 masking, R3 dirty without active change
        mwr(5'h04, 32'hFFFF_FFFF);
        mwr(5'h08, 32'hABCD_1234);
        chk_all("R2 R3");

        // R8 root enable readback; R4 request, R5 wait, R4 zero write ignored
        mwr(5'h00, 32'h0000_0003);
        chk_all("R8 R4");
        for (int i = 0; i < 4; i++) chk_all("R5 wait");
        mwr(5'h00, 32'h0000_0002);
        chk_all("R4 zero write");
        // R6 safe point commit
        @(negedge clk); safe_pt = 1'b1;
        @(negedge clk); safe_pt = 1'b0;
        mcommit();
        chk_all("R6");

        // R7 root off commit exactly one edge after the request edge
        mwr(5'h10, 32'h0000_0077);
        mwr(5'h04, 32'h0000_2503);
        mwr(5'h00, 32'h0000_0001);
        bus_addr = 5'h00; #1;
        chk("R7 pending after request edge", bus_rdata, cmd_img());
        chk("R7 active held", 32'(act_d_o), a_d);
        mcommit();
        @(negedge clk); #1;
        chk("R7 ack next edge", bus_rdata, cmd_img());
        chk_all("R7");

        // R9 write on the copy edge
        mwr(5'h08, 32'h0000_0005);
        mwr(5'h00, 32'h0000_0003);
        @(negedge clk);
        safe_pt = 1'b1; bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h0000_0009;
        @(negedge clk);
        safe_pt = 1'b0; bus_wr = 1'b0;
        mcommit();
        s_m = 32'h9; m_dirty[2] = 1'b1;
        chk_all("R9");

        // R10 unmapped offsets
        mwr(5'h14, 32'hFFFF_FFFF);
        mwr(5'h1C, 32'hFFFF_FFFF);
        mwr(5'h02, 32'hFFFF_FFFF);
        rdchk(5'h14, 32'h0, "R10 rd 0x14");
        rdchk(5'h1C, 32'h0, "R10 rd 0x1C");
        rdchk(5'h02, 32'h0, "R10 rd 0x02");
        chk_all("R10");

        // R11 mode 0 then random rounds
        mwr(5'h04, 32'h0000_0101);
        mwr(5'h00, 32'h0000_0001);
        @(negedge clk);
        mcommit();
        chk_all("R11 mode0");

        for (int it = 0; it < 30; it++) begin
            int unsigned nw;
            nw = 2 + ($urandom % 4);
            for (int k = 0; k < int'(nw); k++) mwr(pick_addr($urandom), $urandom);
            if ($urandom % 2 == 1) mwr(5'h04, ($urandom & 32'hFFFF_CFFF) | 32'h0000_2000);
            chk_all("R2 R3 R10 rand");
            if ($urandom % 2 == 0) begin
                mwr(5'h00, 32'h0000_0001);
                @(negedge clk);
                mcommit();
                chk_all("R7 rand");
            end else begin
                mwr(5'h00, 32'h0000_0003);
                repeat ($urandom % 3) chk_all("R5 rand");
                @(negedge clk); safe_pt = 1'b1;
                @(negedge clk); safe_pt = 1'b0;
                mcommit();
                chk_all("R6 rand");
            end
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule